// File: doc/BRIEF.md
# Burst Splitting Transfer Controller

This block takes a single copy request and turns it into a series of burst commands. A request carries a source byte address, a destination byte address, a byte count, and a burst-width select. The block hands out one command at a time on a valid/ready port. Each command gives the current source address, the current destination address and a length. The requester does not see the splitting. It hands over one request and later receives one single-cycle completion pulse.

The burst length is chosen greedily. It is the smallest of four values:

- the bytes still to move,
- the selected burst cap (64 or 128 bytes),
- the distance from the source address to the next 4 KB page boundary,
- the same distance for the destination address.

Because of this, no command ever spans a page boundary on either side. After every command is accepted, both addresses move forward by the issued length.

The block holds only one request at a time. A new request is taken only once the previous one has signalled completion. A request with a byte count of zero produces no commands and completes at once.

Top module: `bsplit_top`

## Requirements
- R1: After synchronous reset, `req_ready` is 1, and `cmd_valid` and `done` are 0.
- R2: Every command length is nonzero and at most the cap selected at acceptance: 128 bytes when `req_wide` is 1, 64 bytes when it is 0.
- R3: Each command length equals the minimum of the remaining bytes, the cap, (4096 − source[11:0]) and (4096 − destination[11:0]).
- R4: No command crosses a 4 KB boundary on the source side or on the destination side.
- R5: The first command carries the request addresses. Each following command carries the addresses of the one before, advanced by its length. The lengths sum to the requested byte count.
- R6: While `cmd_valid` is 1 and `cmd_ready` is 0, the command stays valid with unchanged address and length fields.
- R7: `done` is high for exactly one cycle per request, in the cycle right after the last command is accepted. `req_ready` returns to 1 in the following cycle.
- R8: A request with byte count 0 issues no commands, and `done` is high in the cycle after acceptance.
- R9: `req_ready` is 0 from the cycle after acceptance until `done` has been given. Request inputs presented in that time have no effect on the commands.
- R10: The burst select is captured when a request is accepted. Changing `req_wide` during a transfer does not alter the commands of that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request may be taken |
| req_src | input | ADDR_W | Source start byte address |
| req_dst | input | ADDR_W | Destination start byte address |
| req_bytes | input | CNT_W | Total bytes to move |
| req_wide | input | 1 | 1 selects the wide (128 B) cap, 0 the narrow (64 B) cap |
| cmd_valid | output | 1 | Burst command offered |
| cmd_ready | input | 1 | Burst command taken |
| cmd_src | output | ADDR_W | Burst source address |
| cmd_dst | output | ADDR_W | Burst destination address |
| cmd_len | output | LEN_W | Burst length in bytes |
| done | output | 1 | One-cycle completion pulse |

## Verification
Random requests use random addresses, and about half of them are placed a few bytes short of a page end. Byte counts vary, and both cap settings are used. This separates the four terms of the minimum: a burst cut by the cap, one cut by the source page, one cut by the destination page, and one cut by the remaining count. Each gives a different length. Directed cases add zero-byte requests, single-byte requests, aligned exact multiples of the cap, and two addresses that reach page ends at different points, so that the source and destination page limits cannot be swapped unnoticed. Random stalls on `cmd_ready` show whether a held command keeps its fields. A cap select flipped mid-transfer, along with garbage on the request inputs, shows whether the block wrongly samples its inputs while busy.

// File: rtl/bsplit_pkg.sv
// Package: shared types of the burst splitting transfer controller.
// Assumes: imported by the control module only.
package bsplit_pkg;

    // Control phase of one request.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,   // waiting for a request
        ST_MOVE   = 2'd1,   // issuing burst commands
        ST_FINISH = 2'd2    // signalling completion
    } bs_state_e;

endpackage

// File: rtl/bsplit_len_calc.sv
// Module: bsplit_len_calc
// Computes the length of the next burst as the minimum of the remaining
// byte count, the selected cap, and the distance to the next page boundary
// from both the source and the destination offsets.
// Assumes: LEN_W <= PG_W + 1, WIDE_BYTES fits in LEN_W bits.
module bsplit_len_calc #(
    parameter int CNT_W        = 32,
    parameter int LEN_W        = 8,
    parameter int PG_W         = 12,
    parameter int NARROW_BYTES = 64,
    parameter int WIDE_BYTES   = 128
) (
    input  logic [PG_W-1:0]  src_off,
    input  logic [PG_W-1:0]  dst_off,
    input  logic [CNT_W-1:0] remain,
    input  logic             wide,
    output logic [LEN_W-1:0] len
);

    localparam logic [PG_W:0]  PAGE_SIZE = {1'b1, {PG_W{1'b0}}};
    localparam logic [LEN_W-1:0] CAP_N   = LEN_W'(NARROW_BYTES);
    localparam logic [LEN_W-1:0] CAP_W   = LEN_W'(WIDE_BYTES);

    logic [PG_W-1:0] offs [2];
    logic [PG_W:0]   gap  [2];
    logic [LEN_W-1:0] cap;
    logic [LEN_W-1:0] rem_cap;
    logic [PG_W:0]    pick;

    assign offs[0] = src_off;
    assign offs[1] = dst_off;

    // Distance to the page boundary, one instance per address side.
    for (genvar g = 0; g < 2; g++) begin : g_gap
        assign gap[g] = PAGE_SIZE - {1'b0, offs[g]};
    end

    // Choose the cap and clip it to the remaining count.
    always_comb begin
        cap = wide ? CAP_W : CAP_N;
        if (remain < CNT_W'(cap)) begin
            rem_cap = remain[LEN_W-1:0];
        end else begin
            rem_cap = cap;
        end
    end

    // Clip further to both page distances.
    always_comb begin
        pick = (PG_W+1)'(rem_cap);
        if (gap[0] < pick) pick = gap[0];
        if (gap[1] < pick) pick = gap[1];
        len = pick[LEN_W-1:0];
    end

endmodule

// File: rtl/bsplit_addr_track.sv
// Module: bsplit_addr_track
// Holds the running source, destination, remaining count and captured cap
// select of the active request. Loads on acceptance, steps on each accepted
// burst command.
// Assumes: load and step never assert together; step_len <= remaining.
module bsplit_addr_track #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] ld_src,
    input  logic [ADDR_W-1:0] ld_dst,
    input  logic [CNT_W-1:0]  ld_rem,
    input  logic              ld_wide,
    input  logic              step,
    input  logic [LEN_W-1:0]  step_len,
    output logic [ADDR_W-1:0] cur_src,
    output logic [ADDR_W-1:0] cur_dst,
    output logic [CNT_W-1:0]  cur_rem,
    output logic              cur_wide,
    output logic              last_burst
);

    // Register the running transfer state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_src  <= '0;
            cur_dst  <= '0;
            cur_rem  <= '0;
            cur_wide <= 1'b0;
        end else if (load) begin
            cur_src  <= ld_src;
            cur_dst  <= ld_dst;
            cur_rem  <= ld_rem;
            cur_wide <= ld_wide;
        end else if (step) begin
            cur_src  <= cur_src + ADDR_W'(step_len);
            cur_dst  <= cur_dst + ADDR_W'(step_len);
            cur_rem  <= cur_rem - CNT_W'(step_len);
        end
    end

    // Flag that the burst on offer drains the request.
    assign last_burst = (cur_rem == CNT_W'(step_len));

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (step_len != '0) && (CNT_W'(step_len) <= cur_rem)); // R5
    AST_WIDE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cur_wide)); // R10

endmodule

// File: rtl/bsplit_fsm.sv
// Module: bsplit_fsm
// Sequences one request: idle/accept, burst issue, completion pulse.
// Assumes: last_burst is valid whenever cmd_valid is high.
module bsplit_fsm
    import bsplit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_zero,
    input  logic cmd_ready,
    input  logic last_burst,
    output logic req_ready,
    output logic cmd_valid,
    output logic done,
    output logic load,
    output logic step
);

    bs_state_e state_q, state_d;

    // Next-state and output decode.
    always_comb begin
        state_d   = state_q;
        req_ready = 1'b0;
        cmd_valid = 1'b0;
        done      = 1'b0;
        load      = 1'b0;
        step      = 1'b0;
        case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    load    = 1'b1;
                    state_d = req_zero ? ST_FINISH : ST_MOVE;
                end
            end
            ST_MOVE: begin
                cmd_valid = 1'b1;
                step      = cmd_ready;
                if (cmd_ready && last_burst) state_d = ST_FINISH;
            end
            ST_FINISH: begin
                done    = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R9
    AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> cmd_valid); // R6
    AST_ZERO_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_zero) |=> (done && !cmd_valid)); // R8
    AST_DONE_REOPEN: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready); // R7

endmodule

// File: rtl/bsplit_top.sv
// Module: bsplit_top
// Burst splitting transfer controller: accepts one copy request and issues
// burst commands capped at 64 or 128 bytes that never cross a page boundary
// on either side, then pulses done once.
// Assumes: PAGE_BYTES is a power of two and at least WIDE_BYTES.
module bsplit_top #(
    parameter int ADDR_W       = 32,
    parameter int CNT_W        = 32,
    parameter int NARROW_BYTES = 64,
    parameter int WIDE_BYTES   = 128,
    parameter int PAGE_BYTES   = 4096,
    localparam int LEN_W       = $clog2(WIDE_BYTES) + 1,
    localparam int PG_W        = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_src,
    input  logic [ADDR_W-1:0] req_dst,
    input  logic [CNT_W-1:0]  req_bytes,
    input  logic              req_wide,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_src,
    output logic [ADDR_W-1:0] cmd_dst,
    output logic [LEN_W-1:0]  cmd_len,
    output logic              done
);

    logic             load, step, last_burst, cur_wide, req_zero;
    logic [CNT_W-1:0] cur_rem;

    // Detect an empty request.
    assign req_zero = (req_bytes == '0);

    bsplit_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_zero   (req_zero),
        .cmd_ready  (cmd_ready),
        .last_burst (last_burst),
        .req_ready  (req_ready),
        .cmd_valid  (cmd_valid),
        .done       (done),
        .load       (load),
        .step       (step)
    );

    bsplit_addr_track #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .LEN_W  (LEN_W)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .ld_src     (req_src),
        .ld_dst     (req_dst),
        .ld_rem     (req_bytes),
        .ld_wide    (req_wide),
        .step       (step),
        .step_len   (cmd_len),
        .cur_src    (cmd_src),
        .cur_dst    (cmd_dst),
        .cur_rem    (cur_rem),
        .cur_wide   (cur_wide),
        .last_burst (last_burst)
    );

    bsplit_len_calc #(
        .CNT_W        (CNT_W),
        .LEN_W        (LEN_W),
        .PG_W         (PG_W),
        .NARROW_BYTES (NARROW_BYTES),
        .WIDE_BYTES   (WIDE_BYTES)
    ) u_len (
        .src_off (cmd_src[PG_W-1:0]),
        .dst_off (cmd_dst[PG_W-1:0]),
        .remain  (cur_rem),
        .wide    (cur_wide),
        .len     (cmd_len)
    );

    AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_len != '0) &&
        (cmd_len <= (cur_wide ? LEN_W'(WIDE_BYTES) : LEN_W'(NARROW_BYTES)))); // R2
    AST_SRC_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (({2'b0, cmd_src[PG_W-1:0]} + (PG_W+2)'(cmd_len))
                       <= (PG_W+2)'(PAGE_BYTES))); // R4
    AST_DST_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (({2'b0, cmd_dst[PG_W-1:0]} + (PG_W+2)'(cmd_len))
                       <= (PG_W+2)'(PAGE_BYTES))); // R4
    AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=>
        ($stable(cmd_src) && $stable(cmd_dst) && $stable(cmd_len))); // R6
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=>
        (!cmd_valid || (cmd_src == $past(cmd_src) + ADDR_W'($past(cmd_len))))); // R5
    AST_NO_CMD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !cmd_valid); // R9

endmodule

// File: tb/tb_bsplit_top.sv
module tb_bsplit_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_wide;
    logic [31:0] req_src, req_dst, req_bytes;
    logic        cmd_valid, cmd_ready;
    logic [31:0] cmd_src, cmd_dst;
    logic [7:0]  cmd_len;
    logic        done;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    bsplit_top dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_src(req_src), .req_dst(req_dst),
        .req_bytes(req_bytes), .req_wide(req_wide),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_len(cmd_len),
        .done(done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint exp_len(input logic [31:0] s, input logic [31:0] d,
                                       input longint rem, input bit w);
        longint m, ts, td;
        m  = w ? 128 : 64;
        if (rem < m) m = rem;
        ts = 4096 - longint'(s[11:0]);
        td = 4096 - longint'(d[11:0]);
        if (ts < m) m = ts;
        if (td < m) m = td;
        return m;
    endfunction

    task automatic run_req(input logic [31:0] s, input logic [31:0] d,
                           input int unsigned n, input bit w, input int stall);
        logic [31:0] ms, md;
        longint mr, el;
        bit stalled;
        int guard;
        ms = s; md = d; mr = n; stalled = 1'b0; guard = 0;
        @(negedge clk);
        req_valid = 1'b1; req_src = s; req_dst = d; req_bytes = n; req_wide = w;
        chk(req_ready == 1'b1, "R9", req_ready, 1);
        @(negedge clk);
        // Garbage on request inputs while busy: must be ignored (R9, R10)
        req_src = $urandom; req_dst = $urandom; req_bytes = $urandom; req_wide = ~w;
        if (n == 0) begin
            chk(done == 1'b1 && cmd_valid == 1'b0, "R8", {done, cmd_valid}, 2);
            req_valid = 1'b0;
            @(negedge clk);
            chk(done == 1'b0 && req_ready == 1'b1, "R7", {done, req_ready}, 1);
            return;
        end
        while (mr > 0) begin
            guard++;
            if (guard > 20000) begin
                chk(1'b0, "R7", guard, 0);
                return;
            end
            chk(req_ready == 1'b0 && done == 1'b0, "R9", {req_ready, done}, 0);
            chk(cmd_valid == 1'b1, "R5", cmd_valid, 1);
            el = exp_len(ms, md, mr, w);
            chk(cmd_len == el, stalled ? "R6" : "R3", cmd_len, el);
            chk(cmd_src == ms, stalled ? "R6" : "R5", cmd_src, ms);
            chk(cmd_dst == md, "R5", cmd_dst, md);
            chk(cmd_len != 0 && cmd_len <= (w ? 128 : 64), "R2", cmd_len, w ? 128 : 64);
            chk((cmd_src[11:0] + cmd_len) <= 4096 && (cmd_dst[11:0] + cmd_len) <= 4096,
                "R4", cmd_len, el);
            cmd_ready = ($urandom_range(0, 99) >= stall);
            if (cmd_ready) begin
                ms = ms + el; md = md + el; mr = mr - el;
            end
            stalled = !cmd_ready;
            req_wide = ~req_wide;
            @(negedge clk);
        end
        cmd_ready = 1'b0;
        chk(done == 1'b1 && cmd_valid == 1'b0, "R7", {done, cmd_valid}, 2);
        req_valid = 1'b0;
        @(negedge clk);
        chk(done == 1'b0 && req_ready == 1'b1, "R7", {done, req_ready}, 1);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);
        rst_n = 1'b0; req_valid = 1'b0; cmd_ready = 1'b0;
        req_src = '0; req_dst = '0; req_bytes = '0; req_wide = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && cmd_valid == 1'b0 && done == 1'b0, "R1",
            {req_ready, cmd_valid, done}, 4);

        // Directed corner cases
        run_req(32'h0000_1000, 32'h0000_2000, 0, 1'b1, 0);     // R8 zero bytes
        run_req(32'h0000_1000, 32'h0000_2000, 1, 1'b0, 0);     // single byte
        run_req(32'h0001_0000, 32'h0002_0000, 512, 1'b1, 0);   // R2 exact multiple, wide
        run_req(32'h0001_0000, 32'h0002_0000, 512, 1'b0, 30);  // R2 narrow, stalls
        run_req(32'h0000_0FFA, 32'h0000_5F00, 300, 1'b1, 0);   // R4 source near page end
        run_req(32'h0000_3000, 32'h0000_6FF1, 300, 1'b1, 50);  // R4 destination near page end
        run_req(32'h0000_7FC0, 32'h0000_8FE0, 9000, 1'b1, 20); // R10 both sides, long
        run_req(32'hFFFF_FFF0, 32'h0000_0000, 0, 1'b0, 0);     // R8 again

        // Constrained random requests
        for (int i = 0; i < 60; i++) begin
            logic [31:0] s, d;
            int unsigned n;
            s = $urandom;
            d = $urandom;
            if ($urandom_range(0, 1) == 1) s[11:0] = 12'(4096 - $urandom_range(1, 200));
            if ($urandom_range(0, 1) == 1) d[11:0] = 12'(4096 - $urandom_range(1, 200));
            n = ($urandom_range(0, 9) == 0) ? 0 : $urandom_range(1, 1500);
            run_req(s, d, n, 1'($urandom_range(0, 1)), $urandom_range(0, 60));
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule